// File: doc/BRIEF.md
# Sparse-Space Bus Address Translator

This block sits on the host side of a host-to-PCI bridge. It turns processor accesses that land in either of two sparse windows (one for PCI I/O space, one for PCI memory space) into single-beat PCI requests. In a sparse window the processor address holds more than the target address. The PCI byte address is the window offset shifted right by five. Offset bits [4:3] hold the transfer length. The two low bits of the recovered address pick the byte lane.

For memory-window accesses, the window offset supplies only the low part of the PCI address. The top bits come from a high-address extension register, which has its own write strobe. Write data is moved onto its byte lane, and active-low byte enables are built from the size and the lane. Read data that comes back from PCI is shifted down from its lane, zero-extended and returned to the processor, in request order. Requests that cannot be translated are accepted but dropped, and an error pulse reports them. Software performs a 64-bit access as two longword accesses: the second one sits 0x80 higher in the processor offset, which is 4 bytes higher on PCI.

Top module: `sparse_xlat`

## Requirements
- R1: A processor address inside the memory window (base 0x2_0000_0000, 31 offset bits) gives `pci_req_io`=0. The PCI address is built from three parts: extension register in bits [31:29], zeros in bits [28:26], and offset bits [30:5] in bits [25:0]. Raising the offset by 0x80 raises the PCI address by 4.
- R2: A processor address inside the I/O window (base 0x3_A000_0000, 29 offset bits) gives `pci_req_io`=1. The PCI address is offset bits [28:5] in bits [23:0], with the upper bits zero.
- R3: Offset bits [4:3] select the size: 0 is a byte, 1 is a 16-bit word, 3 is a 32-bit longword. `pci_req_be_n` is active low, and the lane is PCI address bits [1:0]. A byte clears enable bit `lane`. A word clears bits `lane` and `lane+1`. A longword clears all four bits.
- R4: On a write, the byte goes to bits [8*lane+7:8*lane], the word goes to bits [8*lane+15:8*lane], and a longword passes through unchanged. All other bits are zero.
- R5: For each read, the response data is shifted right by 8*lane and masked to the read's size. It is presented on `cpu_rsp_rdata` with `cpu_rsp_valid` one cycle after `pci_rsp_valid`. Responses come back in the order the reads were issued.
- R6: Four kinds of request are illegal: length code 2, a word at lane 3, a longword at a nonzero lane, and an address outside both windows. Such a request is accepted in the same cycle and issues no PCI request. `cpu_err` pulses for one cycle after its acceptance.
- R7: The extension register resets to 0 and loads `ext_wr_data` when `ext_wr_en` is high. A request accepted in the same cycle as the write still uses the old value. Later requests use the new value.
- R8: For a legal request, `cpu_req_ready` follows `pci_req_ready`. A read is held off, with both `cpu_req_ready` and `pci_req_valid` low, while OUTSTANDING reads are awaiting responses. Writes still pass while reads are held off.
- R9: After reset, `pci_req_valid`, `cpu_rsp_valid` and `cpu_err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_wr_en | input | 1 | Extension register write strobe |
| ext_wr_data | input | EXT_W | Extension register write value |
| cpu_req_valid | input | 1 | Processor request valid |
| cpu_req_ready | output | 1 | Processor request accepted |
| cpu_req_addr | input | CPU_AW | Processor physical address |
| cpu_req_we | input | 1 | 1 = write, 0 = read |
| cpu_req_wdata | input | 32 | Write data, right-justified |
| cpu_rsp_valid | output | 1 | Read data valid |
| cpu_rsp_rdata | output | 32 | Read data, right-justified, zero-extended |
| cpu_err | output | 1 | Pulse: an illegal request was dropped |
| pci_req_valid | output | 1 | PCI request valid |
| pci_req_ready | input | 1 | PCI side accepts the request |
| pci_req_addr | output | 32 | PCI byte address |
| pci_req_io | output | 1 | 1 = I/O space, 0 = memory space |
| pci_req_we | output | 1 | PCI write |
| pci_req_be_n | output | 4 | Active-low byte enables |
| pci_req_wdata | output | 32 | Lane-aligned write data |
| pci_rsp_valid | input | 1 | PCI read data valid |
| pci_rsp_rdata | input | 32 | PCI read data, lane-aligned |

## Verification
The request outputs (address, space flag, enables, lane data and handshake) are combinational. They are due in the same cycle the request is presented, so the bench checks them one time unit after driving the inputs and before the next rising edge. The error pulse and the read response each sit one register after their cause. The bench therefore checks them at the falling edge that follows the accepting edge or the response edge. It also checks, one cycle later still, that the response pulse has ended. The extension register takes effect from the edge of its write strobe. The bench's model updates its own copy only after that edge, so a request presented in the same cycle is compared against the old value.

// File: rtl/sparse_xlat_pkg.sv
package sparse_xlat_pkg;
   localparam int DATA_W = 32;
   localparam int PCI_AW = 32;
   localparam int LANE_W = 2;
   localparam int SHIFT  = 5;

   typedef enum logic [1:0] {
      SZ_BYTE = 2'b00,
      SZ_WORD = 2'b01,
      SZ_RSVD = 2'b10,
      SZ_LONG = 2'b11
   } xfer_size_e;

   typedef struct packed {
      xfer_size_e        size;
      logic [LANE_W-1:0] lane;
   } rd_tag_t;
endpackage

// File: rtl/sparse_decode.sv
module sparse_decode
   import sparse_xlat_pkg::*;
#(
   parameter int                CPU_AW    = 34,
   parameter int                EXT_W     = 3,
   parameter logic [CPU_AW-1:0] MEM_BASE  = 34'h2_0000_0000,
   parameter int                MEM_OFS_W = 31,
   parameter logic [CPU_AW-1:0] IO_BASE   = 34'h3_A000_0000,
   parameter int                IO_OFS_W  = 29
) (
   input  logic [CPU_AW-1:0] cpu_addr,
   input  logic [DATA_W-1:0] cpu_wdata,
   input  logic [EXT_W-1:0]  ext_hi,
   output logic [PCI_AW-1:0] pci_addr,
   output logic              pci_io,
   output xfer_size_e        size,
   output logic [LANE_W-1:0] lane,
   output logic [3:0]        be_n,
   output logic [DATA_W-1:0] lane_wdata,
   output logic              bad
);
   logic                 in_mem, in_io;
   logic [MEM_OFS_W-1:0] mem_ofs;
   logic [IO_OFS_W-1:0]  io_ofs;
   logic [PCI_AW-1:0]    mem_pa, io_pa;
   logic [4:0]           bit_sh;
   logic                 unused_low;

   assign in_mem  = cpu_addr[CPU_AW-1:MEM_OFS_W] == MEM_BASE[CPU_AW-1:MEM_OFS_W];
   assign in_io   = cpu_addr[CPU_AW-1:IO_OFS_W]  == IO_BASE[CPU_AW-1:IO_OFS_W];
   assign mem_ofs = cpu_addr[MEM_OFS_W-1:0];
   assign io_ofs  = cpu_addr[IO_OFS_W-1:0];
   assign unused_low = ^cpu_addr[2:0];

   assign mem_pa = PCI_AW'(mem_ofs >> SHIFT) | {ext_hi, {(PCI_AW-EXT_W){1'b0}}};
   assign io_pa  = PCI_AW'(io_ofs >> SHIFT);

   assign pci_addr = in_mem ? mem_pa : io_pa;
   assign pci_io   = !in_mem;
   assign size     = xfer_size_e'(cpu_addr[4:3]);
   assign lane     = pci_addr[LANE_W-1:0];
   assign bit_sh   = {lane, 3'b000};

   always_comb begin
      be_n       = 4'b1111;
      lane_wdata = '0;
      unique case (size)
         SZ_BYTE: begin
            be_n       = ~(4'b0001 << lane);
            lane_wdata = {24'b0, cpu_wdata[7:0]} << bit_sh;
         end
         SZ_WORD: begin
            be_n       = ~(4'b0011 << lane);
            lane_wdata = {16'b0, cpu_wdata[15:0]} << bit_sh;
         end
         SZ_LONG: begin
            be_n       = 4'b0000;
            lane_wdata = cpu_wdata;
         end
         default: begin
            be_n       = 4'b1111;
            lane_wdata = '0;
         end
      endcase
   end

   assign bad = !(in_mem || in_io)
             || (size == SZ_RSVD)
             || (size == SZ_WORD && lane == 2'd3)
             || (size == SZ_LONG && lane != 2'd0);
endmodule

// File: rtl/lane_fifo.sv
module lane_fifo #(
   parameter int W     = 4,
   parameter int DEPTH = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic [W-1:0] din,
   input  logic         pop,
   output logic [W-1:0] dout,
   output logic         full,
   output logic         empty
);
   localparam int PW = $clog2(DEPTH);
   localparam int CW = $clog2(DEPTH + 1);

   logic [W-1:0]  slots [DEPTH];
   logic [PW-1:0] wr_ptr, rd_ptr;
   logic [CW-1:0] count;

   if (DEPTH < 2) begin : g_depth_chk
      $error("lane_fifo: DEPTH must be at least 2");
   end

   assign full  = count == CW'(DEPTH);
   assign empty = count == '0;
   assign dout  = slots[rd_ptr];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (push && !full)
            wr_ptr <= (wr_ptr == PW'(DEPTH-1)) ? '0 : wr_ptr + 1'b1;
         if (pop && !empty)
            rd_ptr <= (rd_ptr == PW'(DEPTH-1)) ? '0 : rd_ptr + 1'b1;
         unique case ({push && !full, pop && !empty})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (push && !full)
         slots[wr_ptr] <= din;
   end
endmodule

// File: rtl/read_align.sv
module read_align
   import sparse_xlat_pkg::*;
#(
   parameter bit RSP_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [DATA_W-1:0] in_data,
   input  rd_tag_t           tag,
   output logic              out_valid,
   output logic [DATA_W-1:0] out_data
);
   logic [DATA_W-1:0] shifted, trimmed;

   assign shifted = in_data >> {tag.lane, 3'b000};

   always_comb begin
      unique case (tag.size)
         SZ_BYTE: trimmed = {24'b0, shifted[7:0]};
         SZ_WORD: trimmed = {16'b0, shifted[15:0]};
         default: trimmed = shifted;
      endcase
   end

   if (RSP_REG) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
         end else begin
            out_valid <= in_valid;
            if (in_valid)
               out_data <= trimmed;
         end
      end
   end else begin : g_comb
      assign out_valid = in_valid;
      assign out_data  = trimmed;
   end
endmodule

// File: rtl/sparse_xlat.sv
module sparse_xlat
   import sparse_xlat_pkg::*;
#(
   parameter int                CPU_AW      = 34,
   parameter int                EXT_W       = 3,
   parameter logic [CPU_AW-1:0] MEM_BASE    = 34'h2_0000_0000,
   parameter int                MEM_OFS_W   = 31,
   parameter logic [CPU_AW-1:0] IO_BASE     = 34'h3_A000_0000,
   parameter int                IO_OFS_W    = 29,
   parameter int                OUTSTANDING = 4,
   parameter bit                RSP_REG     = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ext_wr_en,
   input  logic [EXT_W-1:0]  ext_wr_data,
   input  logic              cpu_req_valid,
   output logic              cpu_req_ready,
   input  logic [CPU_AW-1:0] cpu_req_addr,
   input  logic              cpu_req_we,
   input  logic [31:0]       cpu_req_wdata,
   output logic              cpu_rsp_valid,
   output logic [31:0]       cpu_rsp_rdata,
   output logic              cpu_err,
   output logic              pci_req_valid,
   input  logic              pci_req_ready,
   output logic [31:0]       pci_req_addr,
   output logic              pci_req_io,
   output logic              pci_req_we,
   output logic [3:0]        pci_req_be_n,
   output logic [31:0]       pci_req_wdata,
   input  logic              pci_rsp_valid,
   input  logic [31:0]       pci_rsp_rdata
);
   localparam int MEM_KEEP = MEM_OFS_W - SHIFT;
   localparam int IO_KEEP  = IO_OFS_W - SHIFT;
   localparam int TAG_W    = $bits(rd_tag_t);

   if (MEM_KEEP + EXT_W > PCI_AW) begin : g_mem_chk
      $error("sparse_xlat: memory offset and extension overlap");
   end
   if (IO_KEEP > PCI_AW || IO_OFS_W < SHIFT + LANE_W) begin : g_io_chk
      $error("sparse_xlat: I/O window width out of range");
   end
   if (MEM_OFS_W < SHIFT + LANE_W || MEM_OFS_W >= CPU_AW || IO_OFS_W >= CPU_AW) begin : g_win_chk
      $error("sparse_xlat: window width out of range");
   end

   logic [EXT_W-1:0] ext_q;
   logic             dec_bad, rd_block, is_rd, fifo_full, fifo_empty, push, pop;
   xfer_size_e       dec_size;
   logic [LANE_W-1:0] dec_lane;
   rd_tag_t          tag_in, tag_out;
   logic             err_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         ext_q <= '0;
      else if (ext_wr_en) ext_q <= ext_wr_data;
   end

   sparse_decode #(
      .CPU_AW   (CPU_AW),
      .EXT_W    (EXT_W),
      .MEM_BASE (MEM_BASE),
      .MEM_OFS_W(MEM_OFS_W),
      .IO_BASE  (IO_BASE),
      .IO_OFS_W (IO_OFS_W)
   ) u_dec (
      .cpu_addr  (cpu_req_addr),
      .cpu_wdata (cpu_req_wdata),
      .ext_hi    (ext_q),
      .pci_addr  (pci_req_addr),
      .pci_io    (pci_req_io),
      .size      (dec_size),
      .lane      (dec_lane),
      .be_n      (pci_req_be_n),
      .lane_wdata(pci_req_wdata),
      .bad       (dec_bad)
   );

   assign is_rd         = !cpu_req_we;
   assign rd_block      = is_rd && fifo_full;
   assign pci_req_valid = cpu_req_valid && !dec_bad && !rd_block;
   assign cpu_req_ready = dec_bad ? 1'b1 : (pci_req_ready && !rd_block);
   assign pci_req_we    = cpu_req_we;

   assign push        = pci_req_valid && pci_req_ready && is_rd;
   assign pop         = pci_rsp_valid && !fifo_empty;
   assign tag_in.size = dec_size;
   assign tag_in.lane = dec_lane;

   lane_fifo #(
      .W    (TAG_W),
      .DEPTH(OUTSTANDING)
   ) u_tags (
      .clk  (clk),
      .rst_n(rst_n),
      .push (push),
      .din  (tag_in),
      .pop  (pop),
      .dout (tag_out),
      .full (fifo_full),
      .empty(fifo_empty)
   );

   read_align #(
      .RSP_REG(RSP_REG)
   ) u_align (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_valid (pop),
      .in_data  (pci_rsp_rdata),
      .tag      (tag_out),
      .out_valid(cpu_rsp_valid),
      .out_data (cpu_rsp_rdata)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) err_q <= 1'b0;
      else        err_q <= cpu_req_valid && dec_bad;
   end
   assign cpu_err = err_q;
endmodule

// File: rtl/sparse_xlat_chk.sv
module sparse_xlat_chk #(
   parameter int MEM_KEEP = 26,
   parameter int IO_KEEP  = 24,
   parameter int EXT_W    = 3,
   parameter bit RSP_REG  = 1'b1
) (
   input logic        clk,
   input logic        rst_n,
   input logic        cpu_req_valid,
   input logic        cpu_req_ready,
   input logic        cpu_err,
   input logic        cpu_rsp_valid,
   input logic        pci_req_valid,
   input logic        pci_req_ready,
   input logic        pci_req_io,
   input logic [31:0] pci_req_addr,
   input logic [3:0]  pci_req_be_n,
   input logic        pci_rsp_valid
);
   localparam logic [31:0] GAP_MASK =
      ((32'h1 << (32 - EXT_W)) - 32'h1) & ~((32'h1 << MEM_KEEP) - 32'h1);

   // R6: an accepted request that made no PCI request is reported next cycle
   a_r6_drop_reports: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_req_valid && cpu_req_ready && !pci_req_valid |=> cpu_err);

   // R6: the error pulse has a dropped request behind it
   a_r6_err_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_err |-> $past(cpu_req_valid && !pci_req_valid));

   // R8: a request that reaches PCI is accepted exactly when PCI accepts it
   a_r8_ready_follows: assert property (@(posedge clk) disable iff (!rst_n)
      pci_req_valid |-> (cpu_req_ready == pci_req_ready));

   // R3: enables cover one, two or four bytes
   a_r3_be_shape: assert property (@(posedge clk) disable iff (!rst_n)
      pci_req_valid |-> ($countones(~pci_req_be_n) == 1 ||
                         $countones(~pci_req_be_n) == 2 ||
                         $countones(~pci_req_be_n) == 4));

   // R1: bits between the window offset and the extension stay zero
   a_r1_mem_gap: assert property (@(posedge clk) disable iff (!rst_n)
      pci_req_valid && !pci_req_io |-> (pci_req_addr & GAP_MASK) == 32'h0);

   // R2: an I/O address carries nothing above the window offset
   a_r2_io_top: assert property (@(posedge clk) disable iff (!rst_n)
      pci_req_valid && pci_req_io |-> (pci_req_addr >> IO_KEEP) == 32'h0);

   // R9: no PCI request without a processor request
   a_r9_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
      pci_req_valid |-> cpu_req_valid);

   if (RSP_REG) begin : g_rsp
      // R5: every processor response follows a PCI response one cycle earlier
      a_r5_rsp_latency: assert property (@(posedge clk) disable iff (!rst_n)
         cpu_rsp_valid |-> $past(pci_rsp_valid));
   end
endmodule

bind sparse_xlat sparse_xlat_chk #(
   .MEM_KEEP(MEM_KEEP),
   .IO_KEEP (IO_KEEP),
   .EXT_W   (EXT_W),
   .RSP_REG (RSP_REG)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .cpu_req_valid(cpu_req_valid),
   .cpu_req_ready(cpu_req_ready),
   .cpu_err      (cpu_err),
   .cpu_rsp_valid(cpu_rsp_valid),
   .pci_req_valid(pci_req_valid),
   .pci_req_ready(pci_req_ready),
   .pci_req_io   (pci_req_io),
   .pci_req_addr (pci_req_addr),
   .pci_req_be_n (pci_req_be_n),
   .pci_rsp_valid(pci_rsp_valid)
);

// File: tb/sparse_xlat_tb.sv
module sparse_xlat_tb;
   localparam int CLK_PERIOD = 10;
   localparam int DEPTH      = 4;
   localparam logic [33:0] MEM_B = 34'h2_0000_0000;
   localparam logic [33:0] IO_B  = 34'h3_A000_0000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ext_wr_en = 1'b0;
   logic [2:0]  ext_wr_data = '0;
   logic        cpu_req_valid = 1'b0;
   logic        cpu_req_ready;
   logic [33:0] cpu_req_addr = '0;
   logic        cpu_req_we = 1'b0;
   logic [31:0] cpu_req_wdata = '0;
   logic        cpu_rsp_valid;
   logic [31:0] cpu_rsp_rdata;
   logic        cpu_err;
   logic        pci_req_valid;
   logic        pci_req_ready = 1'b1;
   logic [31:0] pci_req_addr;
   logic        pci_req_io;
   logic        pci_req_we;
   logic [3:0]  pci_req_be_n;
   logic [31:0] pci_req_wdata;
   logic        pci_rsp_valid = 1'b0;
   logic [31:0] pci_rsp_rdata = '0;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;
   logic [2:0] ext_model = '0;
   logic [3:0] pend_q [$];

   always #(CLK_PERIOD/2) clk = ~clk;

   sparse_xlat #(.OUTSTANDING(DEPTH)) u_dut (
      .clk(clk), .rst_n(rst_n),
      .ext_wr_en(ext_wr_en), .ext_wr_data(ext_wr_data),
      .cpu_req_valid(cpu_req_valid), .cpu_req_ready(cpu_req_ready),
      .cpu_req_addr(cpu_req_addr), .cpu_req_we(cpu_req_we),
      .cpu_req_wdata(cpu_req_wdata),
      .cpu_rsp_valid(cpu_rsp_valid), .cpu_rsp_rdata(cpu_rsp_rdata),
      .cpu_err(cpu_err),
      .pci_req_valid(pci_req_valid), .pci_req_ready(pci_req_ready),
      .pci_req_addr(pci_req_addr), .pci_req_io(pci_req_io),
      .pci_req_we(pci_req_we), .pci_req_be_n(pci_req_be_n),
      .pci_req_wdata(pci_req_wdata),
      .pci_rsp_valid(pci_rsp_valid), .pci_rsp_rdata(pci_rsp_rdata)
   );

   task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   function automatic logic [33:0] mk(input bit io, input logic [25:0] po, input logic [1:0] len);
      if (io) return IO_B | {5'b0, po[23:0], len, 3'b000};
      return MEM_B | {3'b0, po, len, 3'b000};
   endfunction

   // behavioural expectation of one request
   task automatic expect_req(input logic [33:0] a, input logic [31:0] wd,
                             output logic [31:0] pa, output bit io, output logic [3:0] ben,
                             output logic [31:0] wlane, output bit bad, output logic [3:0] tag);
      bit in_mem, in_io;
      int ln, len;
      in_mem = (a >= MEM_B) && (a < MEM_B + 34'h8000_0000);
      in_io  = (a >= IO_B)  && (a < IO_B  + 34'h2000_0000);
      if (in_mem) begin
         pa = {ext_model, 29'(0)} + 32'((a - MEM_B) / 32);
         io = 1'b0;
      end else begin
         pa = 32'((a - IO_B) / 32);
         io = 1'b1;
      end
      len = int'(a[4:3]);
      ln  = int'(pa % 4);
      ben = 4'hF; wlane = 32'h0;
      if (len == 0) begin
         ben[ln] = 1'b0;
         wlane = 32'(wd % 256) * (32'h1 << (8*ln));
      end else if (len == 1) begin
         if (ln < 3) begin ben[ln] = 1'b0; ben[ln+1] = 1'b0; end
         wlane = 32'(wd % 65536) * (32'h1 << (8*ln));
      end else if (len == 3) begin
         ben = 4'h0; wlane = wd;
      end
      bad = !(in_mem || in_io) || len == 2 || (len == 1 && ln == 3) || (len == 3 && ln != 0);
      tag = {2'(len), 2'(ln)};
   endtask

   task automatic drive_req(input string req, input logic [33:0] a, input bit we,
                            input logic [31:0] wd, input bit rdy,
                            input bit ext_go, input logic [2:0] ext_val);
      logic [31:0] pa, wl; bit io, bad; logic [3:0] ben, tag;
      bit block, exp_ready, exp_valid;
      @(negedge clk);
      cpu_req_valid = 1'b1; cpu_req_addr = a; cpu_req_we = we; cpu_req_wdata = wd;
      pci_req_ready = rdy;
      ext_wr_en = ext_go; ext_wr_data = ext_val;
      expect_req(a, wd, pa, io, ben, wl, bad, tag);
      block     = !we && (pend_q.size() >= DEPTH);
      exp_valid = !bad && !block;
      exp_ready = bad ? 1'b1 : (rdy && !block);
      #1;
      check(pci_req_valid == exp_valid, {req, " pci_req_valid"}, 64'(pci_req_valid), 64'(exp_valid));
      check(cpu_req_ready == exp_ready, {req, " cpu_req_ready"}, 64'(cpu_req_ready), 64'(exp_ready));
      if (exp_valid) begin
         check(pci_req_addr == pa, {req, " address"}, 64'(pci_req_addr), 64'(pa));
         check(pci_req_io == io, {req, " space"}, 64'(pci_req_io), 64'(io));
         check(pci_req_be_n == ben, {req, " byte enables"}, 64'(pci_req_be_n), 64'(ben));
         check(pci_req_we == we, {req, " direction"}, 64'(pci_req_we), 64'(we));
         if (we)
            check(pci_req_wdata == wl, {req, " lane data"}, 64'(pci_req_wdata), 64'(wl));
      end
      @(posedge clk);
      if (exp_valid && rdy && !we) pend_q.push_back(tag);
      if (ext_go) ext_model = ext_val;
      @(negedge clk);
      cpu_req_valid = 1'b0; ext_wr_en = 1'b0; pci_req_ready = 1'b1;
      #1;
      check(cpu_err == bad, {req, " error pulse"}, 64'(cpu_err), 64'(bad));
   endtask

   task automatic respond(input string req, input logic [31:0] d);
      logic [3:0] tag; logic [31:0] sh, ex;
      @(negedge clk);
      pci_rsp_valid = 1'b1; pci_rsp_rdata = d;
      tag = pend_q.pop_front();
      sh = d >> (8 * int'(tag[1:0]));
      ex = (tag[3:2] == 2'd0) ? (sh & 32'hFF) : (tag[3:2] == 2'd1) ? (sh & 32'hFFFF) : sh;
      @(negedge clk);
      pci_rsp_valid = 1'b0;
      #1;
      check(cpu_rsp_valid == 1'b1, {req, " response valid"}, 64'(cpu_rsp_valid), 64'h1);
      check(cpu_rsp_rdata == ex, {req, " response data"}, 64'(cpu_rsp_rdata), 64'(ex));
      @(negedge clk);
      #1;
      check(cpu_rsp_valid == 1'b0, {req, " response one cycle"}, 64'(cpu_rsp_valid), 64'h0);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   endtask

   initial begin
      #(CLK_PERIOD * 50000);
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1'b1;
      #1;
      // R9 reset state
      check(pci_req_valid == 1'b0, "R9 req idle", 64'(pci_req_valid), 64'h0);
      check(cpu_rsp_valid == 1'b0, "R9 rsp idle", 64'(cpu_rsp_valid), 64'h0);
      check(cpu_err == 1'b0, "R9 err idle", 64'(cpu_err), 64'h0);

      // R1 R3 R4 memory writes, several sizes and lanes
      drive_req("R1 R3 R4 mem byte lane1", mk(0, 26'h12_3455, 2'd0), 1'b1, 32'h0000_00A5, 1'b1, 1'b0, 3'd0);
      drive_req("R3 R4 mem word lane2",    mk(0, 26'h00_0102, 2'd1), 1'b1, 32'hFFFF_BEEF, 1'b1, 1'b0, 3'd0);
      drive_req("R3 R4 mem byte lane3",    mk(0, 26'h3FF_FFFF, 2'd0), 1'b1, 32'h0000_0077, 1'b1, 1'b0, 3'd0);
      drive_req("R1 R3 mem long",          mk(0, 26'h20_0040, 2'd3), 1'b1, 32'hCAFE_F00D, 1'b1, 1'b0, 3'd0);
      drive_req("R1 quad second half",     mk(0, 26'h20_0040, 2'd3) + 34'h80, 1'b1, 32'h1234_5678, 1'b1, 1'b0, 3'd0);
      // R2 I/O window
      drive_req("R2 R3 io byte lane3",     mk(1, 26'h00_03F7, 2'd0), 1'b1, 32'h0000_005A, 1'b1, 1'b0, 3'd0);
      drive_req("R2 R3 io word lane0",     mk(1, 26'hFF_FFFC, 2'd1), 1'b1, 32'h0000_1357, 1'b1, 1'b0, 3'd0);
      // R7 extension register
      drive_req("R7 same-cycle old ext",   mk(0, 26'h00_0010, 2'd3), 1'b1, 32'h0, 1'b1, 1'b1, 3'd5);
      drive_req("R7 new ext used",         mk(0, 26'h00_0010, 2'd3), 1'b1, 32'h0, 1'b1, 1'b0, 3'd0);
      drive_req("R7 io ignores ext",       mk(1, 26'h00_0010, 2'd3), 1'b1, 32'h0, 1'b1, 1'b0, 3'd0);
      // R6 illegal requests
      drive_req("R6 length code 2",        mk(0, 26'h00_0020, 2'd2), 1'b1, 32'h0, 1'b1, 1'b0, 3'd0);
      drive_req("R6 word lane3",           mk(0, 26'h00_0023, 2'd1), 1'b0, 32'h0, 1'b1, 1'b0, 3'd0);
      drive_req("R6 long lane1",           mk(1, 26'h00_0021, 2'd3), 1'b1, 32'h0, 1'b1, 1'b0, 3'd0);
      drive_req("R6 outside windows",      34'h0_1000_0000, 1'b0, 32'h0, 1'b1, 1'b0, 3'd0);
      // R8 back-pressure
      drive_req("R8 pci not ready",        mk(0, 26'h00_0044, 2'd0), 1'b0, 32'h0, 1'b0, 1'b0, 3'd0);
      // R5 reads, single
      drive_req("R5 read byte lane3",      mk(0, 26'h00_0043, 2'd0), 1'b0, 32'h0, 1'b1, 1'b0, 3'd0);
      respond("R5 byte lane3", 32'hA1B2_C3D4);
      // R5 R8 several outstanding, fill to the limit
      drive_req("R5 read word lane2",      mk(0, 26'h00_0052, 2'd1), 1'b0, 32'h0, 1'b1, 1'b0, 3'd0);
      drive_req("R5 read long",            mk(1, 26'h00_0060, 2'd3), 1'b0, 32'h0, 1'b1, 1'b0, 3'd0);
      drive_req("R5 read byte lane1",      mk(1, 26'h00_0071, 2'd0), 1'b0, 32'h0, 1'b1, 1'b0, 3'd0);
      drive_req("R5 read word lane0",      mk(0, 26'h00_0080, 2'd1), 1'b0, 32'h0, 1'b1, 1'b0, 3'd0);
      drive_req("R8 read held when full",  mk(0, 26'h00_0090, 2'd0), 1'b0, 32'h0, 1'b1, 1'b0, 3'd0);
      drive_req("R8 write passes when full", mk(0, 26'h00_0091, 2'd0), 1'b1, 32'h0000_0033, 1'b1, 1'b0, 3'd0);
      respond("R5 order 1", 32'h1122_3344);
      respond("R5 order 2", 32'h5566_7788);
      respond("R5 order 3", 32'h99AA_BBCC);
      respond("R5 order 4", 32'hDDEE_FF01);
      drive_req("R8 read after drain",     mk(0, 26'h00_0090, 2'd0), 1'b0, 32'h0, 1'b1, 1'b0, 3'd0);
      respond("R5 after drain", 32'h0000_00C8);
      finish_run();
   end
endmodule